// File: doc/BRIEF.md
# Bit Test and Modify Unit

This execution sub-unit handles a family of single-bit and mask-driven memory operations. It takes an 8-bit opcode together with an operand byte already read from memory, the accumulator and an immediate byte. From these it computes the byte to write back, a write strobe, updates for the negative, overflow and zero flags (each with its own enable), and a taken decision for the bit-conditional branches. Operand fetch, address generation and adding the branch displacement are handled outside this unit.

The unit samples one operation per clock edge when `in_valid` is high and holds the result in registers for the following cycle. The opcode fixes the whole behaviour. For the single-bit forms, the upper nibble gives both the bit index and the polarity. The mask forms use the accumulator or the immediate byte as the mask. Opcodes outside the family produce no write, no flag update and no branch.

Top module: `bit_modify_unit`

## Requirements
- R1: An operation sampled on a rising edge with `in_valid` high appears on the outputs after that edge, with `out_valid` high for one cycle. With `in_valid` low, or under reset (`rst_n` low), every output is low.
- R2: For opcodes whose low nibble is 0xF, the tested bit index is opcode[6:4]. With opcode[7]=0, `branch_taken` is high when that bit of the memory byte is 0. With opcode[7]=1, it is high when that bit is 1.
- R3: A bit-branch opcode raises no write strobe and no flag enable.
- R4: For opcodes with low nibble 0x7 and opcode[7]=0, `wr_en` is high and `wr_data` is the memory byte with bit opcode[6:4] forced to 0.
- R5: For opcodes with low nibble 0x7 and opcode[7]=1, `wr_en` is high and `wr_data` is the memory byte with bit opcode[6:4] forced to 1. This is the upper nibble minus 8.
- R6: The bit-clear and bit-set forms leave all flag enables and `branch_taken` low.
- R7: For the mask-set opcodes 0x04 and 0x0C, `wr_en` is high and `wr_data` equals memory OR accumulator.
- R8: For the mask-clear opcodes 0x14 and 0x1C (opcode bit 4 set), `wr_en` is high and `wr_data` equals memory AND NOT accumulator.
- R9: For the R7/R8 forms, all three flag enables are high. V takes bit 6 of the written byte, N takes bit 7 of the written byte, and Z is 1 when the written byte is zero.
- R10: For the immediate-test opcodes 0x83, 0x93, 0xA3 and 0xB3, there is no write and all three flag enables are high. N takes memory bit 7, V takes memory bit 6, and Z is 1 when memory AND immediate is zero.
- R11: Any opcode outside the groups above yields `out_valid` high and every other output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| opcode | input | 8 | Operation code |
| mem_byte | input | 8 | Operand read from memory |
| acc_byte | input | 8 | Accumulator value (mask for set/clear forms) |
| imm_byte | input | 8 | Immediate mask for the test form |
| out_valid | output | 1 | Result registered this cycle |
| wr_en | output | 1 | Write-back strobe |
| wr_data | output | 8 | Byte to write back |
| n_we | output | 1 | Negative flag update enable |
| n_val | output | 1 | New negative flag |
| v_we | output | 1 | Overflow flag update enable |
| v_val | output | 1 | New overflow flag |
| z_we | output | 1 | Zero flag update enable |
| z_val | output | 1 | New zero flag |
| branch_taken | output | 1 | Bit-branch condition met |

## Verification
Every result passes through exactly one register stage. Each output is therefore due in the cycle after the rising edge that sampled the inputs, and it is gone one cycle later unless a new operation is sampled. The bench drives inputs on the falling edge, lets one rising edge pass, and reads the outputs at the next falling edge, midway between edges. Each input is held for a single cycle. When the bench drops `in_valid`, it reads again one cycle later to confirm the outputs have cleared.

// File: rtl/btm_pkg.sv
package btm_pkg;

    localparam int DATA_W = 8;
    localparam int IDX_W  = $clog2(DATA_W);
    localparam int OP_W   = 8;

    typedef enum logic [2:0] {
        K_NONE,
        K_BRANCH,
        K_BITCLR,
        K_BITSET,
        K_MASKSET,
        K_MASKCLR,
        K_MASKTEST
    } op_kind_e;

    typedef struct packed {
        logic              valid;
        logic              wr_en;
        logic [DATA_W-1:0] wr_data;
        logic              n_we;
        logic              n_val;
        logic              v_we;
        logic              v_val;
        logic              z_we;
        logic              z_val;
        logic              br_taken;
    } result_t;

endpackage

// File: rtl/btm_decode.sv
module btm_decode
    import btm_pkg::*;
(
    input  logic [OP_W-1:0]  opcode,
    output op_kind_e         kind,
    output logic [IDX_W-1:0] bit_idx
);

    // The bit index lives in the upper nibble below the polarity bit.
    assign bit_idx = opcode[4 +: IDX_W];

    always_comb begin
        kind = K_NONE;
        if (opcode[3:0] == 4'hF) begin
            kind = K_BRANCH;
        end else if (opcode[3:0] == 4'h7) begin
            kind = opcode[7] ? K_BITSET : K_BITCLR;
        end else begin
            case (opcode)
                8'h04, 8'h0C:               kind = K_MASKSET;
                8'h14, 8'h1C:               kind = K_MASKCLR;
                8'h83, 8'h93, 8'hA3, 8'hB3: kind = K_MASKTEST;
                default:                    kind = K_NONE;
            endcase
        end
    end

endmodule

// File: rtl/btm_bitop.sv
module btm_bitop
    import btm_pkg::*;
(
    input  logic [DATA_W-1:0] mem_byte,
    input  logic [IDX_W-1:0]  bit_idx,
    input  logic              set_mode,
    output logic              bit_hit,
    output logic [DATA_W-1:0] new_byte
);

    logic [DATA_W-1:0] sel;

    // One-hot selector, one decode comparator per bit position.
    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_sel
        assign sel[gi] = (bit_idx == IDX_W'(gi));
    end

    assign bit_hit  = |(mem_byte & sel);
    assign new_byte = set_mode ? (mem_byte | sel) : (mem_byte & ~sel);

endmodule

// File: rtl/btm_maskop.sv
module btm_maskop
    import btm_pkg::*;
(
    input  logic [DATA_W-1:0] mem_byte,
    input  logic [DATA_W-1:0] acc_byte,
    input  logic [DATA_W-1:0] imm_byte,
    input  logic              clr_mode,
    output logic [DATA_W-1:0] mod_byte,
    output logic              test_zero
);

    assign mod_byte  = clr_mode ? (mem_byte & ~acc_byte) : (mem_byte | acc_byte);
    assign test_zero = ~|(mem_byte & imm_byte);

endmodule

// File: rtl/bit_modify_unit.sv
module bit_modify_unit
    import btm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   opcode,
    input  logic [DATA_W-1:0] mem_byte,
    input  logic [DATA_W-1:0] acc_byte,
    input  logic [DATA_W-1:0] imm_byte,
    output logic              out_valid,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              n_we,
    output logic              n_val,
    output logic              v_we,
    output logic              v_val,
    output logic              z_we,
    output logic              z_val,
    output logic              branch_taken
);

    op_kind_e          kind;
    logic [IDX_W-1:0]  bit_idx;
    logic              bit_hit;
    logic [DATA_W-1:0] bit_byte;
    logic [DATA_W-1:0] mask_byte;
    logic              mask_zero;
    result_t           res_d;
    result_t           res_q;

    btm_decode u_decode (
        .opcode  (opcode),
        .kind    (kind),
        .bit_idx (bit_idx)
    );

    btm_bitop u_bitop (
        .mem_byte (mem_byte),
        .bit_idx  (bit_idx),
        .set_mode (kind == K_BITSET),
        .bit_hit  (bit_hit),
        .new_byte (bit_byte)
    );

    btm_maskop u_maskop (
        .mem_byte  (mem_byte),
        .acc_byte  (acc_byte),
        .imm_byte  (imm_byte),
        .clr_mode  (kind == K_MASKCLR),
        .mod_byte  (mask_byte),
        .test_zero (mask_zero)
    );

    always_comb begin
        res_d = '0;
        if (in_valid) begin
            res_d.valid = 1'b1;
            case (kind)
                K_BRANCH: begin
                    res_d.br_taken = opcode[OP_W-1] ? bit_hit : ~bit_hit;
                end
                K_BITCLR, K_BITSET: begin
                    res_d.wr_en   = 1'b1;
                    res_d.wr_data = bit_byte;
                end
                K_MASKSET, K_MASKCLR: begin
                    res_d.wr_en   = 1'b1;
                    res_d.wr_data = mask_byte;
                    res_d.n_we    = 1'b1;
                    res_d.v_we    = 1'b1;
                    res_d.z_we    = 1'b1;
                    res_d.n_val   = mask_byte[DATA_W-1];
                    res_d.v_val   = mask_byte[DATA_W-2];
                    res_d.z_val   = ~|mask_byte;
                end
                K_MASKTEST: begin
                    res_d.n_we  = 1'b1;
                    res_d.v_we  = 1'b1;
                    res_d.z_we  = 1'b1;
                    res_d.n_val = mem_byte[DATA_W-1];
                    res_d.v_val = mem_byte[DATA_W-2];
                    res_d.z_val = mask_zero;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid    = res_q.valid;
    assign wr_en        = res_q.wr_en;
    assign wr_data      = res_q.wr_data;
    assign n_we         = res_q.n_we;
    assign n_val        = res_q.n_val;
    assign v_we         = res_q.v_we;
    assign v_val        = res_q.v_val;
    assign z_we         = res_q.z_we;
    assign z_val        = res_q.z_val;
    assign branch_taken = res_q.br_taken;

endmodule

// File: rtl/btm_chk.sv
module btm_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [7:0]   opcode,
    input logic [W-1:0] mem_byte,
    input logic [W-1:0] acc_byte,
    input logic [W-1:0] imm_byte,
    input logic         out_valid,
    input logic         wr_en,
    input logic [W-1:0] wr_data,
    input logic         n_we,
    input logic         n_val,
    input logic         v_we,
    input logic         v_val,
    input logic         z_we,
    input logic         z_val,
    input logic         branch_taken
);

    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    // R1
    valid_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid && rst_n));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !(wr_en || n_we || v_we || z_we || branch_taken));

    // R3
    branch_no_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
        branch_taken |-> !(wr_en || n_we || v_we || z_we));

    // R4
    bit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(opcode[3:0] == 4'h7 && !opcode[7]))
        |-> (wr_en && wr_data == ($past(mem_byte) & ~(ONE << $past(opcode[6:4])))));

    // R5
    bit_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(opcode[3:0] == 4'h7 && opcode[7]))
        |-> (wr_en && wr_data == ($past(mem_byte) | (ONE << $past(opcode[6:4])))));

    // R6
    bit_form_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(opcode[3:0] == 4'h7))
        |-> !(n_we || v_we || z_we || branch_taken));

    // R7
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(opcode == 8'h04 || opcode == 8'h0C))
        |-> (wr_en && wr_data == ($past(mem_byte) | $past(acc_byte))));

    // R8
    mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(opcode == 8'h14 || opcode == 8'h1C))
        |-> (wr_en && wr_data == ($past(mem_byte) & ~$past(acc_byte))));

    // R9
    mask_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(opcode[7:4] <= 4'h1 && (opcode[3:0] == 4'h4 || opcode[3:0] == 4'hC)))
        |-> (n_we && v_we && z_we && v_val == wr_data[W-2] && n_val == wr_data[W-1]
             && z_val == (wr_data == '0)));

    // R10
    imm_test_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(opcode[3:0] == 4'h3 && opcode[7] && opcode[6:4] <= 3'h3))
        |-> (!wr_en && z_we && z_val == (($past(mem_byte) & $past(imm_byte)) == '0)));

    // R3
    write_branch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_en, branch_taken}));

endmodule

bind bit_modify_unit btm_chk #(.W(btm_pkg::DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .opcode       (opcode),
    .mem_byte     (mem_byte),
    .acc_byte     (acc_byte),
    .imm_byte     (imm_byte),
    .out_valid    (out_valid),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .n_we         (n_we),
    .n_val        (n_val),
    .v_we         (v_we),
    .v_val        (v_val),
    .z_we         (z_we),
    .z_val        (z_val),
    .branch_taken (branch_taken)
);

// File: tb/bit_modify_unit_bench.sv
module bit_modify_unit_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] opcode = 8'h00;
    logic [7:0] mem_byte = 8'h00;
    logic [7:0] acc_byte = 8'h00;
    logic [7:0] imm_byte = 8'h00;
    logic       out_valid, wr_en, n_we, n_val, v_we, v_val, z_we, z_val, branch_taken;
    logic [7:0] wr_data;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    bit_modify_unit u_bit_modify_unit (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .opcode       (opcode),
        .mem_byte     (mem_byte),
        .acc_byte     (acc_byte),
        .imm_byte     (imm_byte),
        .out_valid    (out_valid),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .n_we         (n_we),
        .n_val        (n_val),
        .v_we         (v_we),
        .v_val        (v_val),
        .z_we         (z_we),
        .z_val        (z_val),
        .branch_taken (branch_taken)
    );

    task automatic check(input string req, input string what, input logic [15:0] got,
                         input logic [15:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    // Packs the control outputs: {out_valid, wr_en, n_we, v_we, z_we, branch_taken}
    function automatic logic [5:0] ctl();
        return {out_valid, wr_en, n_we, v_we, z_we, branch_taken};
    endfunction

    // Drive one operation at a falling edge, sample at the next falling edge.
    task automatic issue(input logic [7:0] op, input logic [7:0] m, input logic [7:0] a,
                         input logic [7:0] i);
        @(negedge clk);
        in_valid = 1'b1;
        opcode   = op;
        mem_byte = m;
        acc_byte = a;
        imm_byte = i;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset();
        check("R1", "reset ctl", 16'(ctl()), 16'h0);
        check("R1", "reset data", 16'(wr_data), 16'h0);
    endtask

    task automatic t_bit_clear();
        for (int n = 0; n < 8; n++) begin
            logic [7:0] m = 8'hFF ^ 8'(n * 37);
            issue(8'(n << 4) | 8'h07, m, 8'h5A, 8'h00);
            check("R4", "clear data", 16'(wr_data), 16'(m & ~(8'h01 << n)));
            check("R6", "clear ctl", 16'(ctl()), 16'b110000);
        end
    endtask

    task automatic t_bit_set();
        for (int n = 0; n < 8; n++) begin
            logic [7:0] m = 8'(n * 19);
            issue(8'h87 | 8'(n << 4), m, 8'hA5, 8'h00);
            check("R5", "set data", 16'(wr_data), 16'(m | (8'h01 << n)));
            check("R6", "set ctl", 16'(ctl()), 16'b110000);
        end
    endtask

    task automatic t_branch();
        for (int n = 0; n < 8; n++) begin
            // bit n set in memory
            issue(8'h0F | 8'(n << 4), 8'h01 << n, 8'h00, 8'h00);
            check("R2", "clear-poll, bit 1", 16'(branch_taken), 16'h0);
            issue(8'h8F | 8'(n << 4), 8'h01 << n, 8'h00, 8'h00);
            check("R2", "set-poll, bit 1", 16'(branch_taken), 16'h1);
            // bit n clear, others set
            issue(8'h0F | 8'(n << 4), ~(8'h01 << n), 8'h00, 8'h00);
            check("R2", "clear-poll, bit 0", 16'(branch_taken), 16'h1);
            check("R3", "branch ctl", 16'(ctl()), 16'b100001);
            issue(8'h8F | 8'(n << 4), ~(8'h01 << n), 8'h00, 8'h00);
            check("R2", "set-poll, bit 0", 16'(branch_taken), 16'h0);
            check("R3", "branch ctl quiet", 16'(ctl()), 16'b100000);
        end
    endtask

    task automatic t_mask_set();
        issue(8'h04, 8'h21, 8'h44, 8'h00);
        check("R7", "or data zp", 16'(wr_data), 16'h65);
        check("R9", "or flags", 16'({ctl(), n_val, v_val, z_val}), 16'b111110_010);
        issue(8'h0C, 8'h80, 8'h00, 8'hFF);
        check("R7", "or data abs", 16'(wr_data), 16'h80);
        check("R9", "or flags N", 16'({n_val, v_val, z_val}), 16'b100);
        issue(8'h04, 8'h00, 8'h00, 8'h00);
        check("R9", "or flags Z", 16'({n_val, v_val, z_val}), 16'b001);
    endtask

    task automatic t_mask_clr();
        issue(8'h14, 8'hFF, 8'h3C, 8'h00);
        check("R8", "andn data zp", 16'(wr_data), 16'hC3);
        check("R9", "andn flags", 16'({ctl(), n_val, v_val, z_val}), 16'b111110_110);
        issue(8'h1C, 8'h5A, 8'h5A, 8'h00);
        check("R8", "andn data abs", 16'(wr_data), 16'h00);
        check("R9", "andn flags Z", 16'({n_val, v_val, z_val}), 16'b001);
        // V from result, not operand: memory bit 6 set but cleared by mask
        issue(8'h14, 8'h40, 8'h40, 8'h00);
        check("R9", "andn V from result", 16'(v_val), 16'h0);
    endtask

    task automatic t_imm_test();
        logic [7:0] ops [4] = '{8'h83, 8'h93, 8'hA3, 8'hB3};
        for (int k = 0; k < 4; k++) begin
            issue(ops[k], 8'hC0, 8'hFF, 8'h0F);
            check("R10", "test flags zero", 16'({ctl(), n_val, v_val, z_val}), 16'b101110_111);
            issue(ops[k], 8'h41, 8'h00, 8'h01);
            check("R10", "test flags nonzero", 16'({ctl(), n_val, v_val, z_val}), 16'b101110_010);
        end
    endtask

    task automatic t_other();
        logic [7:0] ops [5] = '{8'hEA, 8'h00, 8'h24, 8'h73, 8'h0E};
        for (int k = 0; k < 5; k++) begin
            issue(ops[k], 8'hFF, 8'hFF, 8'hFF);
            check("R11", "foreign opcode", 16'({ctl(), n_val, v_val, z_val}), 16'b100000_000);
            check("R11", "foreign data", 16'(wr_data), 16'h00);
        end
    endtask

    task automatic t_idle();
        issue(8'h87, 8'h00, 8'h00, 8'h00);
        @(negedge clk);
        check("R1", "idle after op", 16'(ctl()), 16'h0);
    endtask

    initial begin
        #55;
        t_reset();
        rst_n = 1'b1;
        t_bit_clear();
        t_bit_set();
        t_branch();
        t_mask_set();
        t_mask_clr();
        t_imm_test();
        t_other();
        t_idle();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        n_tests++;
        n_fail++;
        $display("FAIL R1 watchdog: actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule